// File: doc/BRIEF.md
# Store Buffer with Load Forwarding

This block sits between a processor's memory port and a single-ported memory. Processor stores are not written to memory straight away. They are held in a small in-order queue of address/data entries, and the queue writes them out one at a time. Processor loads are more urgent than these queued writes. A load whose address is not held in the queue is sent to memory at once, ahead of the waiting writes. A load whose address is held in the queue is answered from the queue and never reaches memory. If several queued stores share that address, the most recently accepted one supplies the data. Because a load that matches the queue is always answered from it, a load never returns memory data older than a queued store to the same address.

The processor side is a request channel with valid/ready handshaking. The request carries a load/store flag, an address and write data. A registered response channel returns load data. The memory side is a request channel with valid/ready handshaking, plus a read-data response. Only one memory load is outstanding at a time. A status output tells the processor that every store has been written out.

Top module: `stbuf_fwd`

## Requirements
- R1: Queued stores leave in acceptance order. While entries are held and no memory load is requested, the memory request is valid with mem_req_write=1 and carries the address and data of the oldest entry. That entry is removed only in a cycle in which mem_req_ready is 1.
- R2: A load that misses the queue and arrives while no load is outstanding drives the memory request in the same cycle, with mem_req_write=0 and the load's address. In that cycle no store is written out. The load is accepted in that cycle only if mem_req_ready is 1.
- R3: A load whose address equals that of a held entry is accepted in the same cycle, even while the queue is full or mem_req_ready is 0. It causes no memory read. cpu_rsp_valid is 1 in the next cycle, with the held data.
- R4: When more than one held entry matches a load address, the response carries the data of the most recently accepted matching store.
- R5: When DEPTH entries are held, cpu_req_ready is 0 for a store request. Load requests are still accepted under R2 and R3. The entry count never exceeds DEPTH.
- R6: drained is 1 exactly when no entry is held. An entry is held until memory accepts its write, so when drained is 1 no store is waiting for memory.
- R7: After a load goes to memory, cpu_req_ready stays 0 until mem_rsp_valid is seen. In the cycle after mem_rsp_valid, cpu_rsp_valid is 1 with that cycle's mem_rsp_data.
- R8: After reset, no entry is held, drained is 1, and both cpu_rsp_valid and mem_req_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Request accepted this cycle when valid |
| cpu_req_store | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | AW | Request address |
| cpu_req_wdata | input | DW | Store data |
| cpu_rsp_valid | output | 1 | Load data valid |
| cpu_rsp_data | output | DW | Load data |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_req_write | output | 1 | 1 = write of a queued store, 0 = load read |
| mem_req_addr | output | AW | Memory request address |
| mem_req_wdata | output | DW | Memory write data |
| mem_rsp_valid | input | 1 | Read data returned for the outstanding load |
| mem_rsp_data | input | DW | Read data |
| drained | output | 1 | No store held in the queue |

## Verification
The memory request fields and cpu_req_ready are combinational. They are due in the same cycle as the request that causes them. Load responses are registered. They are due one cycle after a forwarding acceptance, or one cycle after mem_rsp_valid. drained reflects the entry count after each edge. The bench drives its inputs just after the falling edge. It compares every output 1 ns later against a queue-based model whose state advances once per rising edge, so each result is checked in exactly the cycle in which it falls due.

// File: rtl/stbuf_pkg.sv
package stbuf_pkg;
   typedef enum logic {
      OP_LOAD  = 1'b0,
      OP_STORE = 1'b1
   } stbuf_op_e;

   function automatic bit stbuf_is_pow2(input int n);
      return (n > 0) && ((n & (n - 1)) == 0);
   endfunction
endpackage

// File: rtl/stbuf_queue.sv
module stbuf_queue #(
   parameter int DEPTH = 4,
   parameter int AW    = 32,
   parameter int DW    = 32,
   parameter int PW    = 2,
   parameter int CW    = 3
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       push,
   input  logic [AW-1:0]              push_addr,
   input  logic [DW-1:0]              push_data,
   input  logic                       pop,
   output logic [PW-1:0]              head_ptr,
   output logic [DEPTH-1:0]           ent_valid,
   output logic [DEPTH-1:0][AW-1:0]   ent_addr,
   output logic [DEPTH-1:0][DW-1:0]   ent_data,
   output logic [CW-1:0]              count
);
   logic [DEPTH-1:0][AW-1:0] addr_q;
   logic [DEPTH-1:0][DW-1:0] data_q;
   logic [DEPTH-1:0]         valid_q;
   logic [PW-1:0]            wr_ptr_q;
   logic [PW-1:0]            rd_ptr_q;
   logic [CW-1:0]            cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q  <= '0;
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         cnt_q    <= '0;
      end else begin
         if (push) begin
            valid_q[wr_ptr_q] <= 1'b1;
            wr_ptr_q          <= wr_ptr_q + 1'b1;
         end
         if (pop) begin
            valid_q[rd_ptr_q] <= 1'b0;
            rd_ptr_q          <= rd_ptr_q + 1'b1;
         end
         cnt_q <= cnt_q + CW'(push) - CW'(pop);
      end
   end

   always_ff @(posedge clk) begin
      if (push) begin
         addr_q[wr_ptr_q] <= push_addr;
         data_q[wr_ptr_q] <= push_data;
      end
   end

   assign head_ptr  = rd_ptr_q;
   assign ent_valid = valid_q;
   assign ent_addr  = addr_q;
   assign ent_data  = data_q;
   assign count     = cnt_q;
endmodule

// File: rtl/stbuf_match.sv
module stbuf_match #(
   parameter int DEPTH = 4,
   parameter int AW    = 32,
   parameter int DW    = 32,
   parameter int PW    = 2
) (
   input  logic [AW-1:0]              ld_addr,
   input  logic [PW-1:0]              head_ptr,
   input  logic [DEPTH-1:0]           ent_valid,
   input  logic [DEPTH-1:0][AW-1:0]   ent_addr,
   input  logic [DEPTH-1:0][DW-1:0]   ent_data,
   output logic                       hit,
   output logic [DW-1:0]              hit_data
);
   logic [DEPTH-1:0] eq;

   // one comparator per slot
   for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
      assign eq[i] = ent_valid[i] && (ent_addr[i] == ld_addr);
   end

   // walk slots oldest to youngest; a later match overrides an earlier one
   logic [PW-1:0] slot;
   always_comb begin
      hit      = 1'b0;
      hit_data = '0;
      slot     = '0;
      for (int k = 0; k < DEPTH; k++) begin
         slot = head_ptr + PW'(k);
         if (eq[slot]) begin
            hit      = 1'b1;
            hit_data = ent_data[slot];
         end
      end
   end
endmodule

// File: rtl/stbuf_fwd.sv
module stbuf_fwd #(
   parameter int AW    = 32,
   parameter int DW    = 32,
   parameter int DEPTH = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cpu_req_valid,
   output logic          cpu_req_ready,
   input  logic          cpu_req_store,
   input  logic [AW-1:0] cpu_req_addr,
   input  logic [DW-1:0] cpu_req_wdata,
   output logic          cpu_rsp_valid,
   output logic [DW-1:0] cpu_rsp_data,
   output logic          mem_req_valid,
   input  logic          mem_req_ready,
   output logic          mem_req_write,
   output logic [AW-1:0] mem_req_addr,
   output logic [DW-1:0] mem_req_wdata,
   input  logic          mem_rsp_valid,
   input  logic [DW-1:0] mem_rsp_data,
   output logic          drained
);
   import stbuf_pkg::*;

   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   if (!stbuf_is_pow2(DEPTH) || DEPTH < 2) begin : g_bad_depth
      $error("stbuf_fwd: DEPTH must be a power of two of at least 2");
   end
   if (AW < 1 || DW < 1) begin : g_bad_width
      $error("stbuf_fwd: AW and DW must be positive");
   end

   logic [PW-1:0]            head_ptr;
   logic [DEPTH-1:0]         ent_valid;
   logic [DEPTH-1:0][AW-1:0] ent_addr;
   logic [DEPTH-1:0][DW-1:0] ent_data;
   logic [CW-1:0]            ent_cnt;
   logic                     fwd_hit;
   logic [DW-1:0]            fwd_data;
   logic                     ld_busy_q;
   logic                     rsp_v_q;
   logic [DW-1:0]            rsp_d_q;

   logic is_store, full, has_ent;
   logic ld_try, ld_miss_req, ld_hit_acc, ld_miss_acc;
   logic st_push, st_pop;

   assign is_store    = (stbuf_op_e'(cpu_req_store) == OP_STORE);
   assign has_ent     = (ent_cnt != '0);
   assign full        = (ent_cnt == CW'(DEPTH));
   assign ld_try      = cpu_req_valid && !is_store && !ld_busy_q;
   assign ld_miss_req = ld_try && !fwd_hit;
   assign ld_hit_acc  = ld_try && fwd_hit;
   assign ld_miss_acc = ld_miss_req && mem_req_ready;

   assign cpu_req_ready = !ld_busy_q && (is_store ? !full : (fwd_hit || mem_req_ready));
   assign st_push       = cpu_req_valid && is_store && cpu_req_ready;
   assign st_pop        = !ld_miss_req && has_ent && mem_req_ready;

   stbuf_queue #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .PW(PW), .CW(CW)) u_queue (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (st_push),
      .push_addr (cpu_req_addr),
      .push_data (cpu_req_wdata),
      .pop       (st_pop),
      .head_ptr  (head_ptr),
      .ent_valid (ent_valid),
      .ent_addr  (ent_addr),
      .ent_data  (ent_data),
      .count     (ent_cnt)
   );

   stbuf_match #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .PW(PW)) u_match (
      .ld_addr   (cpu_req_addr),
      .head_ptr  (head_ptr),
      .ent_valid (ent_valid),
      .ent_addr  (ent_addr),
      .ent_data  (ent_data),
      .hit       (fwd_hit),
      .hit_data  (fwd_data)
   );

   // memory port: a missing load takes it, otherwise the oldest entry
   assign mem_req_valid = ld_miss_req || has_ent;
   assign mem_req_write = !ld_miss_req;
   assign mem_req_addr  = ld_miss_req ? cpu_req_addr : ent_addr[head_ptr];
   assign mem_req_wdata = ent_data[head_ptr];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ld_busy_q <= 1'b0;
         rsp_v_q   <= 1'b0;
      end else begin
         rsp_v_q <= ld_hit_acc || (ld_busy_q && mem_rsp_valid);
         if (ld_miss_acc) begin
            ld_busy_q <= 1'b1;
         end else if (mem_rsp_valid) begin
            ld_busy_q <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (ld_hit_acc) begin
         rsp_d_q <= fwd_data;
      end else if (ld_busy_q && mem_rsp_valid) begin
         rsp_d_q <= mem_rsp_data;
      end
   end

   assign cpu_rsp_valid = rsp_v_q;
   assign cpu_rsp_data  = rsp_d_q;
   assign drained       = !has_ent;
endmodule

// File: rtl/stbuf_chk.sv
module stbuf_chk #(
   parameter int DEPTH = 4,
   parameter int CW    = 3
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cpu_req_valid,
   input logic          cpu_req_store,
   input logic          cpu_req_ready,
   input logic          cpu_rsp_valid,
   input logic          mem_req_valid,
   input logic          mem_req_write,
   input logic          mem_req_ready,
   input logic          mem_rsp_valid,
   input logic          drained,
   input logic [CW-1:0] entry_cnt,
   input logic          ld_busy,
   input logic          fwd_hit
);
   logic wr_hs, rd_hs, hit_acc;
   assign wr_hs   = mem_req_valid && mem_req_write && mem_req_ready;
   assign rd_hs   = mem_req_valid && !mem_req_write && mem_req_ready;
   assign hit_acc = cpu_req_valid && !cpu_req_store && cpu_req_ready && fwd_hit;

   assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      entry_cnt <= CW'(DEPTH));

   assert_full_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req_valid && cpu_req_store && entry_cnt == CW'(DEPTH)) |-> !cpu_req_ready);

   assert_store_kept_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_hs |=> (entry_cnt >= $past(entry_cnt)));

   assert_load_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_hs |=> ld_busy);

   assert_hit_no_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
      hit_acc |-> !(mem_req_valid && !mem_req_write));

   assert_hit_reply_R3: assert property (@(posedge clk) disable iff (!rst_n)
      hit_acc |=> cpu_rsp_valid);

   assert_drained_R6: assert property (@(posedge clk) disable iff (!rst_n)
      drained |-> !(mem_req_valid && mem_req_write));

   assert_busy_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ld_busy |-> !cpu_req_ready);

   assert_rsp_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rsp_valid && ld_busy) |=> cpu_rsp_valid);
endmodule

bind stbuf_fwd stbuf_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cpu_req_valid (cpu_req_valid),
   .cpu_req_store (cpu_req_store),
   .cpu_req_ready (cpu_req_ready),
   .cpu_rsp_valid (cpu_rsp_valid),
   .mem_req_valid (mem_req_valid),
   .mem_req_write (mem_req_write),
   .mem_req_ready (mem_req_ready),
   .mem_rsp_valid (mem_rsp_valid),
   .drained       (drained),
   .entry_cnt     (ent_cnt),
   .ld_busy       (ld_busy_q),
   .fwd_hit       (fwd_hit)
);

// File: tb/stbuf_fwd_test.sv
`timescale 1ns/1ps
module stbuf_fwd_test;
   localparam int DEPTH = 4;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cpu_req_valid, cpu_req_store;
   logic [31:0] cpu_req_addr, cpu_req_wdata;
   logic        cpu_req_ready, cpu_rsp_valid;
   logic [31:0] cpu_rsp_data;
   logic        mem_req_valid, mem_req_ready, mem_req_write;
   logic [31:0] mem_req_addr, mem_req_wdata;
   logic        mem_rsp_valid;
   logic [31:0] mem_rsp_data;
   logic        drained;

   always #2 clk = ~clk;

   stbuf_fwd #(.AW(32), .DW(32), .DEPTH(DEPTH)) uut (
      .clk(clk), .rst_n(rst_n),
      .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
      .cpu_req_store(cpu_req_store), .cpu_req_addr(cpu_req_addr),
      .cpu_req_wdata(cpu_req_wdata),
      .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_data(cpu_rsp_data),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
      .mem_req_wdata(mem_req_wdata),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
      .drained(drained)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   // reference model state
   logic [31:0] q_a[$];
   logic [31:0] q_d[$];
   logic [31:0] mem[logic [31:0]];
   logic        m_busy = 0;
   logic        m_rsp_v = 0;
   logic [31:0] m_rsp_d = 0;
   string       m_rsp_tag = "R3";
   int          rd_cnt = 0;
   logic [31:0] rd_data = 0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic step(input logic v, input logic st, input logic [31:0] a,
                       input logic [31:0] d, input logic mrdy);
      logic hit, ldreq, exp_rdy, acc, rspv;
      logic [31:0] hd;
      int nm;
      rspv = (rd_cnt == 1);
      if (rd_cnt > 0) rd_cnt--;
      cpu_req_valid = v; cpu_req_store = st; cpu_req_addr = a; cpu_req_wdata = d;
      mem_req_ready = mrdy;
      mem_rsp_valid = rspv;
      mem_rsp_data  = rspv ? rd_data : 32'h0;
      #1;
      hit = 0; hd = 0; nm = 0;
      foreach (q_a[i]) if (q_a[i] == a) begin hit = 1; hd = q_d[i]; nm++; end
      ldreq   = v && !st && !m_busy && !hit;
      exp_rdy = !m_busy && (st ? (q_a.size() < DEPTH) : (hit || mrdy));
      // outputs due this cycle
      chk(m_busy ? "R7" : (st ? "R5" : "R3"), cpu_req_ready, exp_rdy);
      chk("R2", mem_req_valid, ldreq || q_a.size() > 0);
      if (ldreq) begin
         chk("R2", mem_req_write, 1'b0);
         chk("R2", mem_req_addr, a);
      end else if (q_a.size() > 0) begin
         chk("R1", mem_req_write, 1'b1);
         chk("R1", mem_req_addr, q_a[0]);
         chk("R1", mem_req_wdata, q_d[0]);
      end
      chk("R6", drained, q_a.size() == 0);
      chk(m_rsp_tag, cpu_rsp_valid, m_rsp_v);
      if (m_rsp_v) chk(m_rsp_tag, cpu_rsp_data, m_rsp_d);
      // advance model by one edge
      acc = v && exp_rdy;
      if (acc && !st && hit) begin
         m_rsp_v = 1; m_rsp_d = hd; m_rsp_tag = (nm > 1) ? "R4" : "R3";
      end else if (m_busy && rspv) begin
         m_rsp_v = 1; m_rsp_d = rd_data; m_rsp_tag = "R7";
      end else begin
         m_rsp_v = 0;
      end
      if (ldreq && mrdy) begin
         m_busy = 1; rd_cnt = 2;
         rd_data = mem.exists(a) ? mem[a] : 32'h0;
      end else if (m_busy && rspv) begin
         m_busy = 0;
      end
      if (!ldreq && q_a.size() > 0 && mrdy) begin
         mem[q_a[0]] = q_d[0];
         void'(q_a.pop_front());
         void'(q_d.pop_front());
      end
      if (acc && st) begin
         q_a.push_back(a); q_d.push_back(d);
      end
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] pick [5] = '{32'h10, 32'h14, 32'h18, 32'h1C, 32'h40};
      rst_n = 0;
      cpu_req_valid = 0; cpu_req_store = 0; cpu_req_addr = 0; cpu_req_wdata = 0;
      mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_data = 0;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk); #1;
         if (i > 0) begin
            chk("R8", drained, 1'b1);
            chk("R8", cpu_rsp_valid, 1'b0);
            chk("R8", mem_req_valid, 1'b0);
         end
      end
      rst_n = 1;
      @(negedge clk);
      // fill with memory stalled; repeated address for youngest match
      step(1, 1, 32'h10, 32'hA1, 0);
      step(1, 1, 32'h14, 32'hB0, 0);
      step(1, 1, 32'h10, 32'hA2, 0);
      step(1, 1, 32'h10, 32'hA3, 0);
      step(1, 1, 32'h20, 32'hCC, 0);   // R5: full, store refused
      step(1, 0, 32'h10, 32'h0, 0);    // R4: forwarded youngest while full
      step(1, 0, 32'h14, 32'h0, 0);    // R3: single match
      step(1, 0, 32'h30, 32'h0, 0);    // R2: miss, memory not ready
      step(1, 0, 32'h30, 32'h0, 1);    // R2: miss passes queued stores
      for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 1);
      for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 1);   // R1, R6: drain
      step(1, 0, 32'h10, 32'h0, 1);    // R7: read back drained value
      for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 1);
      // mixed traffic
      for (int i = 0; i < 4000; i++) begin
         step(($urandom % 4) != 0, $urandom % 2, pick[$urandom % 5], $urandom,
              ($urandom % 4) != 0);
      end
      for (int i = 0; i < 12; i++) step(0, 0, 0, 0, 1);
      chk("R6", drained, 1'b1);
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule